// File: doc/BRIEF.md
# Dual-Port Location Contention Arbiter

This block watches the two access ports of a dual-port memory and detects the moment both are selected and pointing at the same word. When that happens it lets one port keep the word and drives an active-low busy flag toward the other port. It also raises an active-high write block for the flagged port, so that the memory core can suppress that port's writes for as long as the conflict lasts.

The winner is whichever port held its enable and address steady from the earlier clock edge. A port counts as newly arrived at an edge if its enable has just gone active, or if its address differs from the value sampled at the previous edge. When both ports arrive at the same edge, the left port wins. Once a winner is chosen it stays latched until the match ends. The busy and block outputs come from a register, so they change one clock after the inputs that cause them.

Top module: `busy_arbiter`

## Requirements
- R1: While either enable is low (inactive), or the two addresses differ, both busy outputs read 1 and both write blocks read 0 after the next rising clock edge.
- R2: When both enables are high and the addresses are equal at a rising edge, exactly one busy output reads 0 after that edge.
- R3: If one port was enabled at the same address on the previous edge and the other port's enable rose or its address changed at this edge, the earlier port wins and the later port's busy goes to 0.
- R4: If both ports arrive at the same edge, the right port's busy goes to 0 and the left port's stays at 1. The two busy outputs are never 0 together.
- R5: Each port's write block reads 1 exactly when that port's busy reads 0.
- R6: Busy is released (reads 1) on the edge after the addresses stop matching or either enable goes low.
- R7: While the match continues, the winner does not change, even when both ports move to a new common address at the same edge.
- R8: While reset is low, both busy outputs read 1 and both write blocks read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| left_en | input | 1 | Left port select, active high |
| left_addr | input | AW | Left port word address |
| right_en | input | 1 | Right port select, active high |
| right_addr | input | AW | Right port word address |
| left_busy_n | output | 1 | Left port busy, active low |
| right_busy_n | output | 1 | Right port busy, active low |
| left_wr_block | output | 1 | Suppress left port writes, active high |
| right_wr_block | output | 1 | Suppress right port writes, active high |

## Verification
The bench goes after arrival order. It tests left-first, right-first and same-edge arrival, and it also tests an arrival through an address change while the enable stays high. A design that ignores address changes, or that inverts the tie rule, flags the wrong port. The bench moves both ports together to a new shared address, which catches a design that re-arbitrates instead of holding the latched winner. It releases the match through an enable and through an address, which catches a design that holds busy one cycle too long. Random traffic over a four-word window makes matches frequent, so a design that ever drives both flags low, or that lets a block drift away from its busy flag, is caught.

// File: rtl/busy_arbiter.sv
module busy_arbiter #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          left_en,
  input  logic [AW-1:0] left_addr,
  input  logic          right_en,
  input  logic [AW-1:0] right_addr,
  output logic          left_busy_n,
  output logic          right_busy_n,
  output logic          left_wr_block,
  output logic          right_wr_block
);

  typedef enum logic [1:0] {FREE = 2'd0, LEFT_OWNS = 2'd1, RIGHT_OWNS = 2'd2} owner_t;

  owner_t        owner, owner_nx;
  logic          l_en_q, r_en_q;
  logic [AW-1:0] l_addr_q, r_addr_q;

  wire match = left_en & right_en & (left_addr == right_addr);
  wire l_new = left_en & (~l_en_q | (left_addr != l_addr_q));
  wire r_new = right_en & (~r_en_q | (right_addr != r_addr_q));

  always_comb begin
    owner_nx = owner;
    if (!match)
      owner_nx = FREE;
    else if (owner == FREE)
      owner_nx = (l_new && !r_new) ? RIGHT_OWNS : LEFT_OWNS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner    <= FREE;
      l_en_q   <= 1'b0;
      r_en_q   <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
    end else begin
      owner    <= owner_nx;
      l_en_q   <= left_en;
      r_en_q   <= right_en;
      l_addr_q <= left_addr;
      r_addr_q <= right_addr;
    end
  end

  assign left_busy_n    = (owner != RIGHT_OWNS);
  assign right_busy_n   = (owner != LEFT_OWNS);
  assign left_wr_block  = ~left_busy_n;
  assign right_wr_block = ~right_busy_n;

  p_never_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!left_busy_n && !right_busy_n));

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !match |=> (left_busy_n && right_busy_n));

  p_one_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> ($countones({~left_busy_n, ~right_busy_n}) == 1));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !(left_busy_n && right_busy_n)) |=> $stable({left_busy_n, right_busy_n}));

  p_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (left_wr_block != left_busy_n) && (right_wr_block != right_busy_n));

endmodule

// File: tb/busy_arbiter_tb.sv
module busy_arbiter_tb;
  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          left_en = 1'b0, right_en = 1'b0;
  logic [AW-1:0] left_addr = '0, right_addr = '0;
  logic          left_busy_n, right_busy_n, left_wr_block, right_wr_block;

  int  n_tests = 0, n_fail = 0;
  bit  done = 0;

  // reference: 0 free, 1 left keeps word, 2 right keeps word
  int            exp_own = 0;
  logic          p_le = 0, p_re = 0;
  logic [AW-1:0] p_la = '0, p_ra = '0;

  always #2.5 clk = ~clk;

  busy_arbiter #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .left_en(left_en), .left_addr(left_addr),
    .right_en(right_en), .right_addr(right_addr),
    .left_busy_n(left_busy_n), .right_busy_n(right_busy_n),
    .left_wr_block(left_wr_block), .right_wr_block(right_wr_block)
  );

  function automatic int next_own(int cur, logic le, logic [AW-1:0] la, logic re,
                                  logic [AW-1:0] ra);
    logic ln, rn;
    if (!(le && re && la == ra)) return 0;
    if (cur != 0) return cur;
    ln = le && (!p_le || la != p_la);
    rn = re && (!p_re || ra != p_ra);
    return (ln && !rn) ? 2 : 1;
  endfunction

  task automatic check(input string tag);
    logic [3:0] got, exp;
    got = {left_busy_n, right_busy_n, left_wr_block, right_wr_block};
    exp = {exp_own != 2, exp_own != 1, exp_own == 2, exp_own == 1};
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: {lbusy_n,rbusy_n,lblk,rblk} actual %b expected %b", tag, got, exp);
    end
  endtask

  // called at a falling edge; checks after the next rising edge
  task automatic apply(input logic le, input logic [AW-1:0] la, input logic re,
                       input logic [AW-1:0] ra, input string tag);
    left_en = le; left_addr = la; right_en = re; right_addr = ra;
    exp_own = next_own(exp_own, le, la, re, ra);
    p_le = le; p_la = la; p_re = re; p_ra = ra;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check("R8 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after reset");

    // left settles first, right arrives later
    apply(1, 11'h123, 0, 11'h123, "R1 right off");
    apply(1, 11'h123, 1, 11'h123, "R3 right late");
    apply(1, 11'h123, 1, 11'h123, "R7 hold");
    apply(1, 11'h123, 0, 11'h123, "R6 release by enable");
    // right settles first, left arrives via address change
    apply(1, 11'h010, 1, 11'h7ff, "R1 differ");
    apply(1, 11'h7ff, 1, 11'h7ff, "R3 left late by address");
    apply(1, 11'h7ff, 1, 11'h7ff, "R5 block follows busy");
    // both move to new common address: winner held
    apply(1, 11'h400, 1, 11'h400, "R7 joint move");
    apply(1, 11'h401, 1, 11'h400, "R6 release by address");
    // same-edge arrival
    apply(0, 11'h0, 0, 11'h0, "R1 idle");
    apply(1, 11'h055, 1, 11'h055, "R4 tie");
    apply(1, 11'h055, 1, 11'h055, "R4 tie hold");
    apply(0, 11'h055, 1, 11'h055, "R6 left off");
    apply(1, 11'h000, 1, 11'h000, "R4 tie by address");

    for (int i = 0; i < 3000; i++) begin
      apply(($urandom % 4) != 0, AW'($urandom % 4),
            ($urandom % 4) != 0, AW'($urandom % 4), "R2 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule